// File: doc/BRIEF.md
# Illegal Address Decode and Fault Capture

This block checks every bus access against a fixed address map. Two regions in the map have programmable sizes, RAM and I/O, so their upper limit moves with two size inputs. An access that lands in a hole in the map, or above a programmed size, is illegal. A write-protect violation reported by a separate unit is also folded in as a fault, but only for data accesses. Instruction-fetch accesses are not write-protected.

A fault raises a one-cycle memory exception pulse. When the faulting master is the DMA engine and the cause is an illegal address, a DMA error interrupt pulse is raised as well. The first fault is latched into a sticky cause register, which software clears with a clear strobe. The address of a faulting data access is latched into a failing-address register. A CPU instruction-fetch fault records its cause but leaves the failing address untouched.

The address map, selected by address bits [31:28], is:

| Region | Bits [31:28] | Checked against |
|---|---|---|
| Boot | 0x0 | Always legal |
| System | 0x1 | Always legal |
| RAM | 0x2 | Programmed RAM size |
| I/O | 0x3 | Programmed I/O size |
| Extended | 0x4 to 0x7 | No checks, always legal |
| Holes | 0x8 to 0xF | Always illegal |

Top module: `addr_guard`

## Requirements
- R1: With bits [31:28] of the address equal to 0x0 or 0x1, an access is legal. With bits [31:28] in 0x8 to 0xF, an access is illegal.
- R2: In the RAM region (0x2000_0000 upward), an address is legal when it is below 0x2000_0000 + (256 KB << ram_size). It is illegal from that limit up to the end of the region.
- R3: In the I/O region (0x3000_0000 upward), an address is legal when it is below 0x3000_0000 + (4 KB << io_size). It is illegal from that limit up to the end of the region.
- R4: With bits [31:28] in 0x4 to 0x7 (the extended areas), an access never raises an illegal-address fault.
- R5: A strobed access that faults drives mem_exc high for exactly the next cycle. A CPU fault never raises dma_err_irq.
- R6: A DMA access to an illegal address also pulses dma_err_irq in that same cycle. A DMA write-protect fault raises only mem_exc.
- R7: A wp_hit on a data access (CPU data or any DMA) is a fault with cause 2'b10. A wp_hit on a CPU instruction fetch is ignored.
- R8: fault_cause records the first fault: 2'b01 for an illegal address, which takes priority, or 2'b10 for write protection. It then holds against later faults until sw_clr, which resets it to 2'b00.
- R9: fail_addr takes the access address when a data-access fault is recorded into fault_cause. A CPU instruction-fetch fault leaves it unchanged.
- R10: After reset all outputs are zero. mem_exc and dma_err_irq stay low in any cycle that does not follow a faulting strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_addr | input | 32 | Access address |
| acc_dma | input | 1 | 1 = DMA master, 0 = CPU |
| acc_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| wp_hit | input | 1 | Write-protect violation from the protection unit |
| ram_size | input | 3 | RAM size, 256 KB << value |
| io_size | input | 3 | I/O size, 4 KB << value |
| sw_clr | input | 1 | Software clear of the cause register |
| mem_exc | output | 1 | Memory exception pulse |
| dma_err_irq | output | 1 | DMA access error interrupt pulse |
| fault_cause | output | 2 | Sticky cause code |
| fail_addr | output | 32 | Failing data-access address |

## Verification
The hardest state to reach is a CPU instruction-fetch fault arriving while the cause register is empty. It must update fault_cause but not fail_addr. Reaching it requires a clear, then a data fault to seed a known fail_addr, then another clear, and only then the fetch fault. The bench builds this with the clear task between accesses, so the held address can be told apart from the fetching address. The sticky-cause behaviour is reached the same way: a second fault is issued with no clear in between.

// File: rtl/addr_guard_pkg.sv
package addr_guard_pkg;

  typedef enum logic [2:0] {
    RG_BOOT,
    RG_SYS,
    RG_RAM,
    RG_IO,
    RG_EXT,
    RG_HOLE
  } region_e;

  localparam logic [1:0] CZ_NONE    = 2'b00;
  localparam logic [1:0] CZ_ILLEGAL = 2'b01;
  localparam logic [1:0] CZ_WPROT   = 2'b10;

  // Map selector from the top nibble of the address.
  function automatic region_e region_of(input logic [3:0] top);
    case (top)
      4'h0:                      return RG_BOOT;
      4'h1:                      return RG_SYS;
      4'h2:                      return RG_RAM;
      4'h3:                      return RG_IO;
      4'h4, 4'h5, 4'h6, 4'h7:    return RG_EXT;
      default:                   return RG_HOLE;
    endcase
  endfunction

  // True when offset lies below 2**lg2.
  function automatic logic below_limit(input logic [63:0] ofs, input logic [6:0] lg2);
    return ofs < (64'd1 << lg2);
  endfunction

endpackage

// File: rtl/ag_region_decode.sv
module ag_region_decode
  import addr_guard_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int SIZE_W       = 3,
  parameter int RAM_UNIT_LG2 = 18,
  parameter int IO_UNIT_LG2  = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] ram_size,
  input  logic [SIZE_W-1:0] io_size,
  output region_e           region,
  output logic              illegal
);
  localparam int OFS_W = ADDR_W - 4;

  logic [63:0] ofs;
  logic [6:0]  ram_lg2;
  logic [6:0]  io_lg2;

  assign ofs     = 64'(addr[OFS_W-1:0]);
  assign ram_lg2 = 7'(RAM_UNIT_LG2) + 7'(ram_size);
  assign io_lg2  = 7'(IO_UNIT_LG2) + 7'(io_size);
  assign region  = region_of(addr[ADDR_W-1:OFS_W]);

  always_comb begin
    case (region)
      RG_RAM:  illegal = !below_limit(ofs, ram_lg2);
      RG_IO:   illegal = !below_limit(ofs, io_lg2);
      RG_HOLE: illegal = 1'b1;
      default: illegal = 1'b0;
    endcase
  end
endmodule

// File: rtl/ag_exc_pulse.sv
module ag_exc_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic fire_irq,
  output logic exc,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc <= 1'b0;
      irq <= 1'b0;
    end else begin
      exc <= fire;
      irq <= fire_irq;
    end
  end
endmodule

// File: rtl/ag_fault_capture.sv
module ag_fault_capture
  import addr_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault,
  input  logic [1:0]        cause_in,
  input  logic              latch_addr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sw_clr,
  output logic [1:0]        cause,
  output logic [ADDR_W-1:0] fail_addr
);
  logic take;
  assign take = fault && ((cause == CZ_NONE) || sw_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause     <= CZ_NONE;
      fail_addr <= '0;
    end else begin
      if (take)        cause <= cause_in;
      else if (sw_clr) cause <= CZ_NONE;
      if (take && latch_addr) fail_addr <= addr;
    end
  end
endmodule

// File: rtl/addr_guard.sv
module addr_guard
  import addr_guard_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int SIZE_W       = 3,
  parameter int RAM_UNIT_LG2 = 18,
  parameter int IO_UNIT_LG2  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_dma,
  input  logic              acc_ifetch,
  input  logic              wp_hit,
  input  logic [SIZE_W-1:0] ram_size,
  input  logic [SIZE_W-1:0] io_size,
  input  logic              sw_clr,
  output logic              mem_exc,
  output logic              dma_err_irq,
  output logic [1:0]        fault_cause,
  output logic [ADDR_W-1:0] fail_addr
);
  region_e    region;
  logic       illegal;
  logic       data_acc;
  logic       wp_eff;
  logic       fault_now;
  logic       dma_fault_now;
  logic [1:0] cause_now;

  ag_region_decode #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
    .RAM_UNIT_LG2(RAM_UNIT_LG2), .IO_UNIT_LG2(IO_UNIT_LG2)
  ) u_dec (
    .addr(acc_addr), .ram_size(ram_size), .io_size(io_size),
    .region(region), .illegal(illegal)
  );

  assign data_acc      = acc_dma || !acc_ifetch;
  assign wp_eff        = wp_hit && data_acc;
  assign fault_now     = acc_valid && (illegal || wp_eff);
  assign dma_fault_now = acc_valid && acc_dma && illegal;
  assign cause_now     = illegal ? CZ_ILLEGAL : CZ_WPROT;

  ag_exc_pulse u_pulse (
    .clk(clk), .rst_n(rst_n),
    .fire(fault_now), .fire_irq(dma_fault_now),
    .exc(mem_exc), .irq(dma_err_irq)
  );

  ag_fault_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .fault(fault_now), .cause_in(cause_now), .latch_addr(data_acc),
    .addr(acc_addr), .sw_clr(sw_clr),
    .cause(fault_cause), .fail_addr(fail_addr)
  );
endmodule

// File: rtl/addr_guard_chk.sv
module addr_guard_chk
  import addr_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_dma,
  input logic              acc_ifetch,
  input logic              sw_clr,
  input logic              mem_exc,
  input logic              dma_err_irq,
  input logic [1:0]        fault_cause,
  input logic [ADDR_W-1:0] fail_addr,
  input region_e           region,
  input logic              illegal,
  input logic              fault_now
);
  a_r4_ext_never_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && region == RG_EXT) |-> !illegal);

  a_r5_exc_follows_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_now |=> mem_exc);

  a_r10_no_spurious_exc: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_now |=> !mem_exc);

  a_r6_irq_with_exc: assert property (@(posedge clk) disable iff (!rst_n)
    dma_err_irq |-> mem_exc);

  a_r7_fetch_wp_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ifetch && !acc_dma && !illegal) |-> !fault_now);

  a_r8_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_cause != CZ_NONE && !sw_clr) |=> $stable(fault_cause));

  a_r9_fetch_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ifetch && !acc_dma) |=> $stable(fail_addr));
endmodule

bind addr_guard addr_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_dma(acc_dma),
  .acc_ifetch(acc_ifetch), .sw_clr(sw_clr), .mem_exc(mem_exc),
  .dma_err_irq(dma_err_irq), .fault_cause(fault_cause), .fail_addr(fail_addr),
  .region(region), .illegal(illegal), .fault_now(fault_now)
);

// File: tb/sim_addr_guard.sv
`timescale 1ns/1ps
module sim_addr_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_dma = 1'b0;
  logic        acc_ifetch = 1'b0;
  logic        wp_hit = 1'b0;
  logic [2:0]  ram_size = '0;
  logic [2:0]  io_size = '0;
  logic        sw_clr = 1'b0;
  logic        mem_exc;
  logic        dma_err_irq;
  logic [1:0]  fault_cause;
  logic [31:0] fail_addr;

  always #4 clk = ~clk;

  addr_guard u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_dma(acc_dma), .acc_ifetch(acc_ifetch), .wp_hit(wp_hit),
    .ram_size(ram_size), .io_size(io_size), .sw_clr(sw_clr),
    .mem_exc(mem_exc), .dma_err_irq(dma_err_irq),
    .fault_cause(fault_cause), .fail_addr(fail_addr)
  );

  typedef struct {
    int          due;
    logic        exc;
    logic        irq;
    logic [1:0]  cause;
    logic [31:0] addr;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int total = 0;
  int fails = 0;
  logic [1:0]  m_cause = 2'b00;
  logic [31:0] m_addr  = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items on the cycle their results appear.
  always begin
    @(posedge clk);
    #4;
    if (rst_n) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        item_t it;
        it = q.pop_front();
        check({it.tag, " exc"},   64'(mem_exc),     64'(it.exc));
        check({it.tag, " irq"},   64'(dma_err_irq), 64'(it.irq));
        check({it.tag, " cause"}, 64'(fault_cause), 64'(it.cause));
        check({it.tag, " addr"},  64'(fail_addr),   64'(it.addr));
      end else begin
        check("R10 idle exc", 64'(mem_exc | dma_err_irq), 64'd0);
      end
    end
  end

  function automatic logic bench_illegal(input logic [31:0] a);
    if (a < 32'h2000_0000) return 1'b0;
    if (a < 32'h3000_0000) return a >= (32'h2000_0000 + (32'h0004_0000 << ram_size));
    if (a < 32'h4000_0000) return a >= (32'h3000_0000 + (32'h0000_1000 << io_size));
    if (a < 32'h8000_0000) return 1'b0;
    return 1'b1;
  endfunction

  task automatic access(input string tag, input logic [31:0] a, input logic dma,
                        input logic fetch, input logic wp);
    item_t it;
    logic ill, wpe, flt;
    @(posedge clk);
    #1;
    acc_addr = a; acc_dma = dma; acc_ifetch = fetch; wp_hit = wp; acc_valid = 1'b1;
    ill = bench_illegal(a);
    wpe = wp && (dma || !fetch);
    flt = ill || wpe;
    if (flt && m_cause == 2'b00) begin
      m_cause = ill ? 2'b01 : 2'b10;
      if (dma || !fetch) m_addr = a;
    end
    it.due = cyc + 1; it.exc = flt; it.irq = flt && dma && ill;
    it.cause = m_cause; it.addr = m_addr; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
    #1;
    acc_valid = 1'b0; wp_hit = 1'b0;
  endtask

  task automatic clear();
    @(posedge clk);
    #1 sw_clr = 1'b1;
    m_cause = 2'b00;
    @(posedge clk);
    #1 sw_clr = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    check("R10 reset exc",   64'(mem_exc), 64'd0);
    check("R10 reset irq",   64'(dma_err_irq), 64'd0);
    check("R10 reset cause", 64'(fault_cause), 64'd0);
    check("R10 reset addr",  64'(fail_addr), 64'd0);

    access("R1 boot",  32'h0000_1000, 0, 0, 0);
    access("R1 sys",   32'h1000_0040, 0, 0, 0);
    access("R1 R5 R9 hole fetch", 32'h9000_0000, 0, 1, 0);
    clear();
    access("R2 ram last word", 32'h2003_FFFC, 0, 0, 0);
    access("R2 R9 ram above",  32'h2004_0000, 0, 0, 0);
    clear();
    ram_size = 3'd2;
    access("R2 ram grown",      32'h2004_0000, 0, 0, 0);
    access("R2 ram grown last", 32'h200F_FFFC, 0, 0, 0);
    access("R2 R6 dma above",   32'h2010_0000, 1, 0, 0);
    clear();
    access("R3 io last",  32'h3000_0FFC, 0, 0, 0);
    access("R3 io above", 32'h3000_1000, 0, 0, 0);
    clear();
    io_size = 3'd3;
    access("R3 io grown", 32'h3000_7FFC, 0, 0, 0);
    access("R4 ext low",  32'h4000_0000, 1, 0, 0);
    access("R4 ext high", 32'h7FFF_FFFC, 1, 0, 0);
    access("R4 ext fetch", 32'h5000_0000, 0, 1, 0);
    access("R7 wp data", 32'h2000_0100, 0, 0, 1);
    access("R8 sticky",  32'hA000_0000, 0, 0, 0);
    clear();
    access("R7 wp fetch ignored", 32'h2000_0200, 0, 1, 1);
    access("R6 R7 wp dma", 32'h2000_0300, 1, 0, 1);
    clear();
    access("R9 seed", 32'hB000_0000, 0, 0, 0);
    clear();
    access("R9 fetch keeps addr", 32'hC000_0000, 0, 1, 0);
    clear();
    access("R8 priority", 32'h2FFF_FFF0, 0, 0, 1);
    repeat (4) @(posedge clk);
    #6;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule